// File: doc/BRIEF.md
# Power-of-two pad debounce filter

This block sits between a pad's input pin and the event logic that reacts to it. It removes bounce and glitches from a slowly changing input. The raw pin is first brought into the clock domain by a short flop chain. The filtered level then moves to a new value only after the synchronized input has held that value for a whole window of slow timebase ticks. The timebase tick is a one-cycle pulse in the fast clock domain, one per 31.25 us period, which is one cycle of a 32 kHz clock.

The window length is a power of two: a 4-bit exponent v sets it to 2^v ticks, so the meaningful range, exponents 3 to 15, covers 250 us up to about 1.024 s. The exponent and an enable flag share one control word. A separate select input decides whether the event logic sees the filtered level or the synchronized level. When the filter is off, the output follows the synchronized input with no added delay.

The filter is a three-state machine. `ST_BYPASS` holds while the filter is inactive. `ST_STABLE` means the output agrees with the input. `ST_PENDING` counts ticks while the input disagrees with the output. The transitions are these. BYPASS to STABLE happens when the filter becomes active. STABLE to PENDING happens when the input differs from the output. PENDING to STABLE happens in two cases: on a bounce back, when the input returns to the output level, or on a commit, when the last tick of the window arrives and the output takes the new level. Any state moves to BYPASS when the filter becomes inactive.

Top module: `pad_debounce_filter`

## Requirements
- R1: The control word `cfg_ctrl` carries the enable flag in bit 0 and the exponent v in bits 4:1. The filter is active only when the enable flag is 1, `filt_sel` is 1 and v is 3 or more.
- R2: While the filter is inactive, `level_out` equals `pad_in` delayed by SYNC_STAGES (default 2) rising clock edges.
- R3: While the filter is active, a new input level reaches `level_out` only after it has been held for 2^v sampled ticks. With the tick held high and the state stable, a `pad_in` change driven before edge C+1 appears after edge C+3+2^v and not after edge C+2+2^v.
- R4: If the synchronized input returns to the output level before the window completes, the count is discarded. A later change needs a full fresh window.
- R5: Only clock edges that sample `tick` high advance the window. With `tick` low the output does not change, however long the new level is held.
- R6: An exponent below 3 puts the block in bypass as described in R2, even with enable and select both set.
- R7: With `filt_sel` clear, the block is in bypass as described in R2, whatever the control word holds.
- R8: The tick counter holds the full 2^15-tick window without wrapping. With v=15, the output changes after exactly 32768 ticks.
- R9: After reset, `level_out` is 0 and the counter is clear. When the filter is enabled, the output continues from the current synchronized level without a step.
- R10: Disabling the filter while a count is pending passes the synchronized input straight through and clears the count. Re-enabling starts from a full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse, one per 31.25 us |
| pad_in | input | 1 | Raw pad level, asynchronous to `clk` |
| cfg_ctrl | input | EXP_W+1 | Bit 0 enable, bits EXP_W:1 exponent v |
| filt_sel | input | 1 | 1 routes the filtered level to the output, 0 bypasses the filter |
| level_out | output | 1 | Level handed to the event logic |

## Verification
The assertions assume that the tick is a single-cycle pulse in the `clk` domain. They also assume that the configuration is driven synchronously to `clk`, and that `pad_in` is free of X once reset is released. Under those conditions, they tie every filtered-mode output change to a tick edge that follows a pending state. The bench changes `pad_in` and the configuration only at falling clock edges. It changes the configuration a few cycles apart from pad changes, except in the one deliberate disable-during-count case. It holds the tick high or low for whole stretches, so that every window length can be predicted to the exact edge.

// File: rtl/deb_pkg.sv
package deb_pkg;

    // Filter state encoding
    typedef enum logic [1:0] {
        ST_BYPASS  = 2'd0,
        ST_STABLE  = 2'd1,
        ST_PENDING = 2'd2
    } deb_state_e;

    // Control-word layout
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_EXP_LSB = 1;

endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/deb_cfg_decode.sv
module deb_cfg_decode
    import deb_pkg::*;
#(
    parameter int EXP_W   = 4,
    parameter int MIN_EXP = 3,
    parameter int CNT_W   = 1 << EXP_W
) (
    input  logic [EXP_W:0]   cfg_ctrl,
    input  logic             filt_sel,
    output logic             filt_active,
    output logic [CNT_W-1:0] last_cnt
);
    logic [EXP_W-1:0] exp_v;
    logic             exp_ok;

    assign exp_v  = cfg_ctrl[CTRL_EXP_LSB +: EXP_W];
    assign exp_ok = (exp_v >= EXP_W'(MIN_EXP));

    // Filtering needs enable, select and a meaningful exponent
    assign filt_active = cfg_ctrl[CTRL_EN_BIT] & filt_sel & exp_ok;

    // Terminal count is window length minus one: 2^v - 1
    assign last_cnt = (CNT_W'(1) << exp_v) - CNT_W'(1);
endmodule

// File: rtl/deb_fsm.sv
module deb_fsm
    import deb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             din,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             level_q,
    output deb_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o
);
    deb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;
    logic             differs;
    logic             window_done;

    assign differs     = (din != out_q);
    assign window_done = tick & (cnt_q >= last_cnt);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: begin
                if (active) state_d = ST_STABLE;
            end
            ST_STABLE: begin
                if (!active)     state_d = ST_BYPASS;
                else if (differs) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (!active)          state_d = ST_BYPASS;
                else if (!differs)    state_d = ST_STABLE;
                else if (window_done) state_d = ST_STABLE;
            end
            default: state_d = ST_BYPASS;
        endcase
    end

    // Output level and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (!active) begin
            out_q <= din;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_BYPASS: begin
                    cnt_q <= '0;
                end
                ST_STABLE: begin
                    cnt_q <= '0;
                end
                ST_PENDING: begin
                    if (!differs) begin
                        cnt_q <= '0;
                    end else if (window_done) begin
                        out_q <= din;
                        cnt_q <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign level_q = out_q;
    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/pad_debounce_filter.sv
module pad_debounce_filter
    import deb_pkg::*;
#(
    parameter int EXP_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_EXP     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pad_in,
    input  logic [EXP_W:0] cfg_ctrl,
    input  logic         filt_sel,
    output logic         level_out
);
    localparam int CNT_W = 1 << EXP_W;

    logic             pad_sync;
    logic             filt_active;
    logic [CNT_W-1:0] last_cnt;
    logic             filt_level;
    deb_state_e       fsm_state;
    logic [CNT_W-1:0] fsm_cnt;

    deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pad_sync)
    );

    deb_cfg_decode #(.EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .CNT_W(CNT_W)) u_decode (
        .cfg_ctrl    (cfg_ctrl),
        .filt_sel    (filt_sel),
        .filt_active (filt_active),
        .last_cnt    (last_cnt)
    );

    deb_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (filt_active),
        .tick     (tick),
        .din      (pad_sync),
        .last_cnt (last_cnt),
        .level_q  (filt_level),
        .state_o  (fsm_state),
        .cnt_o    (fsm_cnt)
    );

    // Bypass passes the synchronized level with no added register
    assign level_out = filt_active ? filt_level : pad_sync;
endmodule

// File: rtl/deb_filter_checker.sv
module deb_filter_checker
    import deb_pkg::*;
#(
    parameter int EXP_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_EXP     = 3,
    parameter int CNT_W       = 1 << EXP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             pad_in,
    input logic [EXP_W:0]   cfg_ctrl,
    input logic             filt_sel,
    input logic             level_out,
    input deb_state_e       fsm_state,
    input logic [CNT_W-1:0] fsm_cnt
);
    localparam logic [CNT_W-1:0] HALF_RANGE = CNT_W'(1) << (CNT_W - 1);

    logic [SYNC_STAGES-1:0] pad_pipe;
    logic [1:0]             since_rst;
    logic                   chk_active;

    assign chk_active = cfg_ctrl[0] & filt_sel &
                        (cfg_ctrl[EXP_W:1] >= EXP_W'(MIN_EXP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_pipe  <= '0;
            since_rst <= '0;
        end else begin
            pad_pipe  <= {pad_pipe[SYNC_STAGES-2:0], pad_in};
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
        end
    end

    // R2: bypass shows pad_in delayed by the synchronizer depth
    assert_bypass_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_active |-> (level_out == pad_pipe[SYNC_STAGES-1]));

    // R5: in filtered mode the output moves only on an edge that sampled a tick
    assert_tick_gates_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && chk_active && $past(chk_active) && !$past(tick))
        |-> $stable(level_out));

    // R3: a filtered-mode change is always preceded by a pending count
    assert_change_after_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && chk_active && $past(chk_active) && (level_out != $past(level_out)))
        |-> ($past(fsm_state) == ST_PENDING));

    // R8: counter never reaches its upper half
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_cnt < HALF_RANGE);

    // R10: count is clear outside the pending state
    assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_PENDING) |-> (fsm_cnt == '0));
endmodule

bind pad_debounce_filter deb_filter_checker #(
    .EXP_W       (EXP_W),
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_EXP     (MIN_EXP)
) u_deb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pad_in    (pad_in),
    .cfg_ctrl  (cfg_ctrl),
    .filt_sel  (filt_sel),
    .level_out (level_out),
    .fsm_state (fsm_state),
    .fsm_cnt   (fsm_cnt)
);

// File: tb/test_pad_debounce_filter.sv
`timescale 1ns/1ps
module test_pad_debounce_filter;
    localparam int EXP_W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b1;
    logic         pad_in = 1'b0;
    logic [EXP_W:0] cfg_ctrl = '0;
    logic         filt_sel = 1'b0;
    logic         level_out;

    pad_debounce_filter #(.EXP_W(EXP_W)) i_pad_debounce_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pad_in    (pad_in),
        .cfg_ctrl  (cfg_ctrl),
        .filt_sel  (filt_sel),
        .level_out (level_out)
    );

    always #2.5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        logic        val;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    task automatic expect_at(input int unsigned at, input logic val, input string tag);
        exp_t e;
        e.at = at; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare away from the clock edge
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if (e.at != cyc || level_out !== e.val) begin
                miscompares++;
                $display("FAIL %s: level_out=%b expected %b (cycle %0d, due %0d)",
                         e.tag, level_out, e.val, cyc, e.at);
            end
        end
    end

    task automatic wait_until(input int unsigned at);
        while (cyc < at) @(negedge clk);
    endtask

    task automatic set_cfg(input logic en, input logic [EXP_W-1:0] v, input logic sel);
        @(negedge clk);
        cfg_ctrl = {v, en};
        filt_sel = sel;
        repeat (3) @(negedge clk);
    endtask

    task automatic drive_pad(input logic val, input int unsigned old_off,
                             input int unsigned new_off, input logic old_val,
                             input string tag);
        int unsigned c;
        @(negedge clk);
        c = cyc;
        pad_in = val;
        expect_at(c + old_off, old_val, tag);
        expect_at(c + new_off, val, tag);
        wait_until(c + new_off);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            if (sb.size() != 0) begin
                miscompares++;
                $display("FAIL all: %0d expectations left unchecked, expected 0", sb.size());
            end
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog: run not finished, expected completion");
        done = 1'b0;
        finish_run();
    end

    initial begin
        int unsigned c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        @(negedge clk);
        expect_at(cyc + 1, 1'b0, "R9 reset level");
        wait_until(cyc + 1);

        // R2: filter disabled, two-edge synchronizer pass-through
        set_cfg(1'b0, 4'd3, 1'b1);
        drive_pad(1'b1, 1, 2, 1'b0, "R2 bypass rise");
        drive_pad(1'b0, 1, 2, 1'b1, "R2 bypass fall");

        // R1/R3: v=3 window is 8 ticks; R9 enabling keeps current level
        set_cfg(1'b1, 4'd3, 1'b1);
        expect_at(cyc + 1, 1'b0, "R9 enable no step");
        drive_pad(1'b1, 10, 11, 1'b0, "R3 v=3 rise");
        drive_pad(1'b0, 10, 11, 1'b1, "R3 v=3 fall");
        set_cfg(1'b1, 4'd4, 1'b1);
        drive_pad(1'b1, 18, 19, 1'b0, "R1 v=4 rise");

        // R4: bounce back before the window ends, then a full fresh window
        @(negedge clk);
        c = cyc;
        pad_in = 1'b0;
        repeat (5) @(negedge clk);
        pad_in = 1'b1;
        expect_at(c + 6, 1'b1, "R4 bounce held");
        expect_at(c + 25, 1'b1, "R4 bounce discarded");
        wait_until(c + 25);
        drive_pad(1'b0, 18, 19, 1'b1, "R4 restart window");

        // R5: ticks gate the count
        @(negedge clk);
        tick = 1'b0;
        c = cyc;
        pad_in = 1'b1;
        expect_at(c + 40, 1'b0, "R5 no ticks no change");
        wait_until(c + 40);
        @(negedge clk);
        c = cyc;
        tick = 1'b1;
        expect_at(c + 15, 1'b0, "R5 15 ticks");
        expect_at(c + 16, 1'b1, "R5 16 ticks");
        wait_until(c + 16);

        // R6: exponent below 3 bypasses
        set_cfg(1'b1, 4'd2, 1'b1);
        drive_pad(1'b0, 1, 2, 1'b1, "R6 v=2 bypass");
        set_cfg(1'b1, 4'd0, 1'b1);
        drive_pad(1'b1, 1, 2, 1'b0, "R6 v=0 bypass");

        // R7: select clear bypasses
        set_cfg(1'b1, 4'd3, 1'b0);
        drive_pad(1'b0, 1, 2, 1'b1, "R7 select clear");

        // R10: disable mid-count, then a fresh full window
        set_cfg(1'b1, 4'd4, 1'b1);
        @(negedge clk);
        c = cyc;
        pad_in = 1'b1;
        repeat (8) @(negedge clk);
        cfg_ctrl[0] = 1'b0;
        expect_at(c + 9, 1'b1, "R10 disable passes input");
        wait_until(c + 12);
        @(negedge clk);
        c = cyc;
        cfg_ctrl[0] = 1'b1;
        pad_in = 1'b0;
        expect_at(c + 18, 1'b1, "R10 fresh window old");
        expect_at(c + 19, 1'b0, "R10 fresh window new");
        wait_until(c + 19);

        // R8: longest window, 32768 ticks
        set_cfg(1'b1, 4'd15, 1'b1);
        drive_pad(1'b1, 2 + 32768, 3 + 32768, 1'b0, "R8 v=15");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule